// File: doc/BRIEF.md
# Frequency Offset Tracking Loop

This block follows the carrier frequency error of an FSK receiver (2-FSK, GFSK or MSK). On each symbol strobe it takes a signed error sample from the discriminator, shifts it right by a programmable amount and adds the result to a saturating 16-bit estimate. The estimate is clamped to a selectable fraction of the channel bandwidth. It is cleared when a reception starts and held while the receiver is idle. The current estimate is always visible as a status word. A separate synthesizer correction register changes only when software writes it, normally with a copy of the status word.

A four-state controller sequences each reception. `ST_IDLE` holds the estimate while the receiver is off. Leaving `ST_IDLE` (transition *start*, on `rx_en` high) clears the estimate and enters `ST_WAIT_CS` when the carrier gate is enabled, or `ST_TRACK_PRE` when it is not. `ST_WAIT_CS` freezes the estimate. It moves to `ST_TRACK_PRE` (transition *carrier*) when carrier sense is seen or the gate enable is cleared. `ST_TRACK_PRE` tracks with the pre-sync gain and moves to `ST_TRACK_POST` (transition *sync*) on the sync-found strobe. `ST_TRACK_POST` tracks with the post-sync gain. From any of the three active states, `rx_en` low takes the controller back to `ST_IDLE` (transition *stop*), which also forgets that sync was found.

Top module: `foc_track_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the estimate and the synthesizer correction become 0 and the controller returns to idle, so any sync-found state is lost.
- R2: In the cycle after `rx_en` is seen high in the idle state, the estimate reads 0. A symbol strobe in that same edge is discarded.
- R3: In a tracking state, each edge with `sym_valid` high and OOK mode off adds `err_in >>> (gain+1)` to the estimate. The shift is arithmetic, so it rounds toward minus infinity, and `err_in` is two's complement.
- R4: The pre-sync gain field is used until the edge at which `sync_found` is sampled high, including that edge. The post-sync gain field is used from the next edge onward.
- R5: After every update the estimate lies within ±limit, where `lim_sel` 0, 1, 2, 3 gives a limit of 0, `chan_bw>>3`, `chan_bw>>2`, `chan_bw>>1`. A result beyond the limit is replaced by the nearer bound.
- R6: While `mod_ook` is high, the estimate does not change during a reception.
- R7: With `cs_gate_en` high when a reception starts, the estimate is frozen until `cs_in` has been sampled high. A symbol on the same edge as `cs_in` is still discarded. Clearing `cs_gate_en` also releases the freeze, one edge later.
- R8: `est_status` equals the estimate at all times and keeps its last value while `rx_en` is low, even with symbol strobes present.
- R9: `synth_corr` takes the value of `corr_wdata` on an edge with `corr_wr` high and otherwise keeps its value, whatever the estimate does.
- R10: After `rx_en` goes low, the next reception starts again with the pre-sync gain.
- R11: An edge with `sym_valid` low leaves the estimate unchanged, whatever `err_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enabled; a rising level starts a reception |
| sym_valid | input | 1 | Error sample strobe, one per symbol |
| err_in | input | 16 | Signed per-symbol frequency error |
| cs_in | input | 1 | Carrier sense level |
| sync_found | input | 1 | Sync word detected strobe |
| mod_ook | input | 1 | On-off keying selected; tracking disabled |
| cs_gate_en | input | 1 | Freeze tracking until carrier sense |
| gain_pre | input | 2 | Pre-sync gain, shift = value+1 |
| gain_post | input | 2 | Post-sync gain, shift = value+1 |
| lim_sel | input | 2 | Tracking range select (0, BW/8, BW/4, BW/2) |
| chan_bw | input | 16 | Channel bandwidth in error LSB units |
| corr_wr | input | 1 | Software write strobe for the correction |
| corr_wdata | input | 16 | Value to load into the correction |
| est_status | output | 16 | Current offset estimate (signed) |
| synth_corr | output | 16 | Synthesizer offset correction (signed) |

## Verification
On every cycle, the embedded properties check the following:
- after an update, the estimate lies within the limit in force;
- the estimate is frozen in the idle state, while waiting for carrier and in OOK mode;
- a start clears the estimate;
- the controller takes the *sync* and *stop* transitions;
- the correction register moves only on a write.

The arithmetic itself can only be shown by the bench's scenarios and its cycle-by-cycle model. This covers the shift amounts and their floor rounding, which gain applies on the edge where the sync strobe arrives, and the discarding of a symbol that coincides with the start or with carrier sense.

// File: rtl/foc_pkg.sv
package foc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_CS    = 2'd1,
        ST_TRACK_PRE  = 2'd2,
        ST_TRACK_POST = 2'd3
    } foc_state_e;
endpackage

// File: rtl/foc_limit_sel.sv
module foc_limit_sel #(
    parameter int BW_W  = 16,
    parameter int ACC_W = 16
) (
    input  logic [BW_W-1:0]  chan_bw,
    input  logic [1:0]       lim_sel,
    output logic [ACC_W-1:0] limit
);
    // Range fraction: shift of the bandwidth per select code; code 0 is a zero range.
    logic [BW_W-1:0] bw_frac;

    always_comb begin
        unique case (lim_sel)
            2'd0:    bw_frac = '0;
            2'd1:    bw_frac = chan_bw >> 3;
            2'd2:    bw_frac = chan_bw >> 2;
            default: bw_frac = chan_bw >> 1;
        endcase
    end

    generate
        if (ACC_W > BW_W) begin : g_wide
            assign limit = {{(ACC_W-BW_W){1'b0}}, bw_frac};
        end else begin : g_same
            assign limit = bw_frac[ACC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/foc_gain_shift.sv
module foc_gain_shift #(
    parameter int ERR_W  = 16,
    parameter int GAIN_W = 2
) (
    input  logic [ERR_W-1:0]  err_in,
    input  logic [GAIN_W-1:0] gain,
    output logic [ERR_W-1:0]  err_scaled
);
    localparam int SH_W = GAIN_W + 1;

    logic [SH_W-1:0] sh_amt;

    assign sh_amt     = {1'b0, gain} + SH_W'(1);
    assign err_scaled = $signed(err_in) >>> sh_amt;
endmodule

// File: rtl/foc_sat_add.sv
module foc_sat_add #(
    parameter int ACC_W = 16,
    parameter int ERR_W = 16
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ERR_W-1:0] delta,
    input  logic [ACC_W-1:0] limit,
    output logic [ACC_W-1:0] acc_out
);
    localparam int SUM_W = ACC_W + 2;

    logic signed [SUM_W-1:0] acc_x;
    logic signed [SUM_W-1:0] delta_x;
    logic signed [SUM_W-1:0] sum_x;
    logic signed [SUM_W-1:0] pos_lim;
    logic signed [SUM_W-1:0] neg_lim;

    assign acc_x   = {{(SUM_W-ACC_W){acc_in[ACC_W-1]}}, acc_in};
    assign delta_x = {{(SUM_W-ERR_W){delta[ERR_W-1]}}, delta};
    assign pos_lim = {{(SUM_W-ACC_W){1'b0}}, limit};
    assign neg_lim = -pos_lim;
    assign sum_x   = acc_x + delta_x;

    always_comb begin
        if (sum_x > pos_lim) begin
            acc_out = pos_lim[ACC_W-1:0];
        end else if (sum_x < neg_lim) begin
            acc_out = neg_lim[ACC_W-1:0];
        end else begin
            acc_out = sum_x[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/foc_track_top.sv
module foc_track_top
    import foc_pkg::*;
#(
    parameter int ERR_W  = 16,
    parameter int ACC_W  = 16,
    parameter int BW_W   = 16,
    parameter int GAIN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sym_valid,
    input  logic [ERR_W-1:0]  err_in,
    input  logic              cs_in,
    input  logic              sync_found,
    input  logic              mod_ook,
    input  logic              cs_gate_en,
    input  logic [GAIN_W-1:0] gain_pre,
    input  logic [GAIN_W-1:0] gain_post,
    input  logic [1:0]        lim_sel,
    input  logic [BW_W-1:0]   chan_bw,
    input  logic              corr_wr,
    input  logic [ACC_W-1:0]  corr_wdata,
    output logic [ACC_W-1:0]  est_status,
    output logic [ACC_W-1:0]  synth_corr
);
    foc_state_e st_q, st_d;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  corr_q;
    logic [ACC_W-1:0]  acc_next;
    logic [ACC_W-1:0]  limit;
    logic [ERR_W-1:0]  err_scaled;
    logic [GAIN_W-1:0] gain_sel;
    logic              tracking;
    logic              upd;
    logic              clr;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rx_en) st_d = cs_gate_en ? ST_WAIT_CS : ST_TRACK_PRE;
            end
            ST_WAIT_CS: begin
                if (!rx_en)                    st_d = ST_IDLE;
                else if (cs_in || !cs_gate_en) st_d = ST_TRACK_PRE;
            end
            ST_TRACK_PRE: begin
                if (!rx_en)          st_d = ST_IDLE;
                else if (sync_found) st_d = ST_TRACK_POST;
            end
            ST_TRACK_POST: begin
                if (!rx_en) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign tracking = (st_q == ST_TRACK_PRE) || (st_q == ST_TRACK_POST);
    assign upd      = tracking && rx_en && sym_valid && !mod_ook;
    assign clr      = (st_q == ST_IDLE) && rx_en;
    assign gain_sel = (st_q == ST_TRACK_POST) ? gain_post : gain_pre;

    foc_limit_sel #(.BW_W(BW_W), .ACC_W(ACC_W)) u_limit (
        .chan_bw (chan_bw),
        .lim_sel (lim_sel),
        .limit   (limit)
    );

    foc_gain_shift #(.ERR_W(ERR_W), .GAIN_W(GAIN_W)) u_gain (
        .err_in     (err_in),
        .gain       (gain_sel),
        .err_scaled (err_scaled)
    );

    foc_sat_add #(.ACC_W(ACC_W), .ERR_W(ERR_W)) u_sat (
        .acc_in  (acc_q),
        .delta   (err_scaled),
        .limit   (limit),
        .acc_out (acc_next)
    );

    // Output registers: estimate and software correction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            corr_q <= '0;
        end else begin
            if (clr)      acc_q <= '0;
            else if (upd) acc_q <= acc_next;
            if (corr_wr)  corr_q <= corr_wdata;
        end
    end

    assign est_status = acc_q;
    assign synth_corr = corr_q;

    // R5
    range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ($signed(acc_q) <= $signed({1'b0, $past(limit)}) &&
                 $signed(acc_q) >= -$signed({1'b0, $past(limit)})));

    // R6
    ook_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_ook && st_q != ST_IDLE) |=> $stable(acc_q));

    // R7
    cs_wait_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_CS) |=> $stable(acc_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !rx_en) |=> $stable(est_status));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && rx_en) |=> (est_status == '0));

    // R9
    corr_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_wr |=> $stable(synth_corr));

    // R4
    sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK_PRE && rx_en && sync_found) |=> (st_q == ST_TRACK_POST));

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !rx_en) |=> (st_q == ST_IDLE));
endmodule

// File: tb/foc_track_top_tb_top.sv
module foc_track_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        sym_valid = 1'b0;
    logic [15:0] err_in = '0;
    logic        cs_in = 1'b0;
    logic        sync_found = 1'b0;
    logic        mod_ook = 1'b0;
    logic        cs_gate_en = 1'b0;
    logic [1:0]  gain_pre = 2'd0;
    logic [1:0]  gain_post = 2'd3;
    logic [1:0]  lim_sel = 2'd3;
    logic [15:0] chan_bw = 16'd4000;
    logic        corr_wr = 1'b0;
    logic [15:0] corr_wdata = '0;
    logic [15:0] est_status;
    logic [15:0] synth_corr;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";

    // model state
    int m_acc = 0;
    int m_corr = 0;
    int m_st = 0; // 0 idle, 1 wait carrier, 2 pre-sync, 3 post-sync

    always #2.5 clk = ~clk;

    foc_track_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sym_valid(sym_valid),
        .err_in(err_in), .cs_in(cs_in), .sync_found(sync_found),
        .mod_ook(mod_ook), .cs_gate_en(cs_gate_en), .gain_pre(gain_pre),
        .gain_post(gain_post), .lim_sel(lim_sel), .chan_bw(chan_bw),
        .corr_wr(corr_wr), .corr_wdata(corr_wdata),
        .est_status(est_status), .synth_corr(synth_corr)
    );

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        int nst, g, lim, d, s;
        if (!rst_n) begin
            m_acc = 0; m_corr = 0; m_st = 0;
        end else begin
            if (corr_wr) m_corr = int'($signed(corr_wdata));
            nst = m_st;
            if (m_st == 0) begin
                if (rx_en) begin
                    m_acc = 0;
                    nst = cs_gate_en ? 1 : 2;
                end
            end else if (!rx_en) begin
                nst = 0;
            end else begin
                if (m_st == 1 && (cs_in || !cs_gate_en)) nst = 2;
                if (m_st == 2 && sync_found) nst = 3;
                if (m_st >= 2 && sym_valid && !mod_ook) begin
                    g = (m_st == 2) ? int'(gain_pre) : int'(gain_post);
                    case (lim_sel)
                        2'd0: lim = 0;
                        2'd1: lim = int'(chan_bw) / 8;
                        2'd2: lim = int'(chan_bw) / 4;
                        default: lim = int'(chan_bw) / 2;
                    endcase
                    d = int'($signed(err_in)) >>> (g + 1);
                    s = m_acc + d;
                    if (s > lim) s = lim;
                    if (s < -lim) s = -lim;
                    m_acc = s;
                end
            end
            m_st = nst;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one cycle and compare against the model at the falling edge
    task automatic cyc();
        @(negedge clk);
        check({cur_req, " est"}, int'($signed(est_status)), m_acc);
        check({cur_req, " corr"}, int'($signed(synth_corr)), m_corr);
    endtask

    task automatic sym(input int e);
        err_in = 16'(e);
        sym_valid = 1'b1;
        cyc();
        sym_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        check("R1 est", int'($signed(est_status)), 0);
        check("R1 corr", int'($signed(synth_corr)), 0);
        rst_n = 1'b1;
        cyc();

        // R3 basic accumulation, pre gain shift 1
        cur_req = "R3";
        rx_en = 1'b1;
        cyc();
        sym(100); sym(100); sym(100);
        check("R3", int'($signed(est_status)), 150);
        sym(-7);
        check("R3 floor", int'($signed(est_status)), 146);

        // R11 no strobe, no change
        cur_req = "R11";
        err_in = 16'd500;
        cyc(); cyc(); cyc();
        check("R11", int'($signed(est_status)), 146);

        // R4 sync edge uses pre gain, later post gain
        cur_req = "R4";
        sync_found = 1'b1;
        sym(32);
        sync_found = 1'b0;
        check("R4 pre on sync edge", int'($signed(est_status)), 162);
        sym(160);
        check("R4 post", int'($signed(est_status)), 172);

        // R5 saturation
        cur_req = "R5";
        sym(32767);
        check("R5 pos", int'($signed(est_status)), 2000);
        sym(-32768); sym(-32768);
        check("R5 neg", int'($signed(est_status)), -2000);
        lim_sel = 2'd1;
        sym(-16);
        check("R5 bw/8", int'($signed(est_status)), -500);
        lim_sel = 2'd0;
        sym(16);
        check("R5 zero", int'($signed(est_status)), 0);
        lim_sel = 2'd3;

        // R6 OOK
        cur_req = "R6";
        mod_ook = 1'b1;
        sym(1600);
        check("R6", int'($signed(est_status)), 0);
        mod_ook = 1'b0;
        sym(1600);
        check("R6 resume", int'($signed(est_status)), 100);

        // R8 idle hold
        cur_req = "R8";
        rx_en = 1'b0;
        cyc();
        sym(800);
        check("R8", int'($signed(est_status)), 100);

        // R2 start clears, strobe at start discarded
        cur_req = "R2";
        rx_en = 1'b1;
        sym(800);
        check("R2", int'($signed(est_status)), 0);

        // R10 restart uses pre gain again
        cur_req = "R10";
        sym(800);
        check("R10", int'($signed(est_status)), 400);

        // R7 carrier gate
        cur_req = "R7";
        rx_en = 1'b0; cyc();
        cs_gate_en = 1'b1;
        rx_en = 1'b1; cyc();
        sym(200); sym(200);
        check("R7 frozen", int'($signed(est_status)), 0);
        cs_in = 1'b1;
        sym(200);
        cs_in = 1'b0;
        check("R7 cs edge", int'($signed(est_status)), 0);
        sym(200);
        check("R7 released", int'($signed(est_status)), 100);
        rx_en = 1'b0; cyc();
        rx_en = 1'b1; cyc();
        sym(200);
        cs_gate_en = 1'b0;
        cyc();
        sym(200);
        check("R7 gate cleared", int'($signed(est_status)), 100);

        // R9 correction load
        cur_req = "R9";
        corr_wdata = est_status;
        corr_wr = 1'b1; cyc();
        corr_wr = 1'b0;
        check("R9 load", int'($signed(synth_corr)), 100);
        corr_wdata = 16'd555; cyc();
        sym(200);
        check("R9 hold", int'($signed(synth_corr)), 100);

        // Mixed random traffic against the model
        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            rx_en      = ($urandom_range(0, 19) != 0);
            sym_valid  = $urandom_range(0, 1) == 1;
            err_in     = 16'($urandom);
            cs_in      = $urandom_range(0, 3) == 0;
            sync_found = $urandom_range(0, 7) == 0;
            mod_ook    = $urandom_range(0, 9) == 0;
            cs_gate_en = $urandom_range(0, 1) == 1;
            gain_pre   = 2'($urandom);
            gain_post  = 2'($urandom);
            lim_sel    = 2'($urandom);
            chan_bw    = 16'($urandom);
            corr_wr    = $urandom_range(0, 7) == 0;
            corr_wdata = 16'($urandom);
            cyc();
        end
        summary();
        $finish;
    end
endmodule